// File: doc/BRIEF.md
# Transmit Mailbox Status Arbiter

This block keeps the status of a small set of transmit mailboxes (three by default) in a CAN-style controller. Software issues three kinds of one-cycle command strobes per mailbox: queue a transmission, abandon a queued transmission, and acknowledge a finished request. A transmit engine reports the outcome of each attempt on a named mailbox. The outcome is success, lost arbitration or error.

From this the block keeps, for each mailbox, a pending bit (shown as an empty flag), an abort-in-progress flag, a request-finished flag and three outcome flags. It also ranks the pending mailboxes by a programmable per-mailbox key. It marks the one that would be sent last whenever two or more are waiting. It produces a mailbox index that names the first free slot, or, when every slot is occupied, the slot that would be sent last. Software uses that index to pick where to load the next frame.

Top module: `mbx_status_arbiter`

## Requirements
- R1: After reset every empty flag is 1, the abort, finished, success, arbitration-lost, error and lowest-rank flags are 0, and the index output is 0.
- R2: A mailbox's empty flag is the inverse of its pending bit. A queue strobe on an empty mailbox makes it pending on the next cycle and clears its finished and outcome flags. A queue strobe on a pending mailbox changes nothing.
- R3: Ranking uses the key: a smaller key ranks higher, and on equal keys the lower index ranks higher. A mailbox's lowest-rank flag is 1 only when it is pending, at least two mailboxes are pending, and it ranks below every other pending mailbox. Otherwise all lowest-rank flags are 0.
- R4: While any mailbox is empty, the index output is the lowest-numbered empty mailbox. When all are pending, it is the lowest-ranked mailbox.
- R5: An abandon strobe on a pending mailbox sets its abort flag on the next cycle. The flag stays set until the mailbox becomes empty. An abandon strobe on an empty mailbox has no effect.
- R6: An engine report with result code 2'b00 (success) on a pending mailbox empties it in the next cycle. In that same cycle it sets the finished and success flags and clears the arbitration-lost, error and abort flags.
- R7: An engine report with result code 2'b01 (arbitration lost) on a pending mailbox sets arbitration-lost and clears success and error. Code 2'b10 or 2'b11 (error) sets error and clears success and arbitration-lost. In both cases the mailbox stays pending and its finished flag is unchanged. At most one outcome flag is ever set.
- R8: An acknowledge strobe clears the mailbox's finished, success, arbitration-lost and error flags. A completion on that mailbox in the same cycle takes precedence.
- R9: A mailbox whose abort flag is set is emptied on the next clock edge unless a success report for it arrives on that edge. Emptying it this way sets finished, clears success and keeps the previous failure reason.
- R10: An engine report naming an empty mailbox changes nothing.
- R11: A success report on a mailbox whose abort flag is set completes as a success, and success is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req_i | input | NUM_MBOX | Queue-transmission strobe per mailbox |
| sw_abort_i | input | NUM_MBOX | Abandon strobe per mailbox |
| sw_clr_i | input | NUM_MBOX | Acknowledge (write-one-to-clear finished flag) per mailbox |
| key_i | input | NUM_MBOX*KEY_W | Priority key per mailbox, mailbox 0 in the low bits |
| eng_done_i | input | 1 | Engine reports an attempt outcome this cycle |
| eng_mbox_i | input | IDX_W | Mailbox the report refers to |
| eng_result_i | input | 2 | 00 success, 01 arbitration lost, 10/11 error |
| empty_o | output | NUM_MBOX | Mailbox has no pending request |
| low_o | output | NUM_MBOX | Mailbox is lowest-ranked of two or more pending |
| code_o | output | IDX_W | First free mailbox, or lowest-ranked when full |
| abort_o | output | NUM_MBOX | Abort in progress |
| done_o | output | NUM_MBOX | Last request finished |
| ok_o | output | NUM_MBOX | Last attempt succeeded |
| arb_o | output | NUM_MBOX | Last failure was lost arbitration |
| err_o | output | NUM_MBOX | Last failure was an error |

## Verification
The properties assume that the engine names only mailbox indices below NUM_MBOX, and that command strobes and reports are sampled only on clock edges. The index output is checked only as a valid slot number under that assumption. The bench drives every strobe for exactly one cycle, shortly after a rising edge. It never issues a report with an index beyond the last mailbox. It reprograms keys only between edges, so the combinational ranking settles before the next sample.

// File: rtl/mbx_pkg.sv
// Package: shared encodings for the transmit mailbox status arbiter.
// Assumes: nothing beyond the engine result encoding listed here.
package mbx_pkg;

    // Outcome reported by the transmit engine for one attempt.
    typedef enum logic [1:0] {
        ENG_OK      = 2'b00,
        ENG_ARBLOST = 2'b01,
        ENG_ERR     = 2'b10,
        ENG_ERR_ALT = 2'b11
    } eng_res_e;

    // Stored state of one mailbox.
    typedef struct packed {
        logic pend;
        logic abort;
        logic done;
        logic ok;
        logic arb;
        logic err;
    } slot_state_t;

    localparam slot_state_t SLOT_RESET = '{pend: 1'b0, abort: 1'b0, done: 1'b0,
                                           ok: 1'b0, arb: 1'b0, err: 1'b0};

endpackage

// File: rtl/mbx_slot.sv
// Module: mbx_slot
// Holds the pending, abort, finished and outcome state of one mailbox.
// Assumes: hit_i is high only when the engine report names this mailbox;
// all strobes are single-cycle and synchronous to clk.
module mbx_slot
    import mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        abort_i,
    input  logic        clr_i,
    input  logic        hit_i,
    input  logic [1:0]  res_i,
    output slot_state_t state_o
);

    slot_state_t cur_q;
    slot_state_t nxt;
    logic        succ;
    logic        fail;
    logic        abort_fin;

    // Classify this cycle's engine report and pending abort.
    always_comb begin
        succ      = hit_i && cur_q.pend && (eng_res_e'(res_i) == ENG_OK);
        fail      = hit_i && cur_q.pend && (eng_res_e'(res_i) != ENG_OK);
        abort_fin = cur_q.abort && cur_q.pend && !succ;
    end

    // Next-state: software actions first, hardware completions override.
    always_comb begin
        nxt = cur_q;
        if (clr_i) begin
            nxt.done = 1'b0;
            nxt.ok   = 1'b0;
            nxt.arb  = 1'b0;
            nxt.err  = 1'b0;
        end
        if (req_i && !cur_q.pend) begin
            nxt.pend = 1'b1;
            nxt.done = 1'b0;
            nxt.ok   = 1'b0;
            nxt.arb  = 1'b0;
            nxt.err  = 1'b0;
        end
        if (abort_i && cur_q.pend) begin
            nxt.abort = 1'b1;
        end
        if (fail) begin
            nxt.ok  = 1'b0;
            nxt.arb = (eng_res_e'(res_i) == ENG_ARBLOST);
            nxt.err = (eng_res_e'(res_i) != ENG_ARBLOST);
        end
        if (succ) begin
            nxt.pend  = 1'b0;
            nxt.abort = 1'b0;
            nxt.done  = 1'b1;
            nxt.ok    = 1'b1;
            nxt.arb   = 1'b0;
            nxt.err   = 1'b0;
        end else if (abort_fin) begin
            nxt.pend  = 1'b0;
            nxt.abort = 1'b0;
            nxt.done  = 1'b1;
            nxt.ok    = 1'b0;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= SLOT_RESET;
        end else begin
            cur_q <= nxt;
        end
    end

    assign state_o = cur_q;

endmodule

// File: rtl/mbx_rank.sv
// Module: mbx_rank
// Marks the pending mailbox that ranks below all other pending ones.
// Assumes: smaller key ranks higher; equal keys resolve toward lower index.
module mbx_rank #(
    parameter int NUM_MBOX = 3,
    parameter int KEY_W    = 8
) (
    input  logic [NUM_MBOX-1:0]       pend_i,
    input  logic [NUM_MBOX*KEY_W-1:0] key_i,
    output logic [NUM_MBOX-1:0]       low_o
);

    localparam int CNT_W = $clog2(NUM_MBOX + 1);

    logic [CNT_W-1:0] n_pend;
    logic             multi;

    // Count pending mailboxes to decide whether any flag may be raised.
    always_comb begin
        n_pend = CNT_W'($countones(pend_i));
        multi  = (n_pend >= CNT_W'(2));
    end

    // One comparator column per mailbox.
    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_col
        logic [KEY_W-1:0] key_self;
        logic             beaten;

        assign key_self = key_i[i*KEY_W +: KEY_W];

        // Mailbox i is lowest if every other pending mailbox outranks it.
        always_comb begin
            beaten = 1'b1;
            for (int j = 0; j < NUM_MBOX; j++) begin
                if (j != i && pend_i[j]) begin
                    if (!((key_i[j*KEY_W +: KEY_W] < key_self) ||
                          ((key_i[j*KEY_W +: KEY_W] == key_self) && (j < i)))) begin
                        beaten = 1'b0;
                    end
                end
            end
        end

        assign low_o[i] = pend_i[i] && multi && beaten;
    end

endmodule

// File: rtl/mbx_code.sv
// Module: mbx_code
// Picks the index of the lowest free mailbox, else the lowest-ranked one.
// Assumes: when no mailbox is empty, low_i is one-hot.
module mbx_code #(
    parameter int NUM_MBOX = 3,
    parameter int IDX_W    = 2
) (
    input  logic [NUM_MBOX-1:0] empty_i,
    input  logic [NUM_MBOX-1:0] low_i,
    output logic [IDX_W-1:0]    code_o
);

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] low_idx;

    // Priority encode, scanning downward so the lowest set index wins.
    always_comb begin
        free_idx = '0;
        low_idx  = '0;
        for (int i = NUM_MBOX - 1; i >= 0; i--) begin
            if (empty_i[i]) free_idx = IDX_W'(i);
            if (low_i[i])   low_idx  = IDX_W'(i);
        end
    end

    // Select between the free slot and the lowest-ranked pending slot.
    assign code_o = (|empty_i) ? free_idx : low_idx;

endmodule

// File: rtl/mbx_status_arbiter.sv
// Module: mbx_status_arbiter (top)
// Tracks NUM_MBOX transmit mailboxes and produces their status word:
// empty, abort, finished, outcome and lowest-rank flags, plus a slot index.
// Assumes: eng_mbox_i < NUM_MBOX whenever eng_done_i is high.
module mbx_status_arbiter #(
    parameter int NUM_MBOX = 3,
    parameter int KEY_W    = 8,
    localparam int IDX_W   = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MBOX-1:0]       sw_req_i,
    input  logic [NUM_MBOX-1:0]       sw_abort_i,
    input  logic [NUM_MBOX-1:0]       sw_clr_i,
    input  logic [NUM_MBOX*KEY_W-1:0] key_i,
    input  logic                      eng_done_i,
    input  logic [IDX_W-1:0]          eng_mbox_i,
    input  logic [1:0]                eng_result_i,
    output logic [NUM_MBOX-1:0]       empty_o,
    output logic [NUM_MBOX-1:0]       low_o,
    output logic [IDX_W-1:0]          code_o,
    output logic [NUM_MBOX-1:0]       abort_o,
    output logic [NUM_MBOX-1:0]       done_o,
    output logic [NUM_MBOX-1:0]       ok_o,
    output logic [NUM_MBOX-1:0]       arb_o,
    output logic [NUM_MBOX-1:0]       err_o
);

    import mbx_pkg::*;

    logic [NUM_MBOX-1:0] pend;

    // One state slot per mailbox, each decoding its own engine report.
    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_slot
        slot_state_t st;
        logic        hit;

        assign hit = eng_done_i && (eng_mbox_i == IDX_W'(i));

        mbx_slot u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (sw_req_i[i]),
            .abort_i (sw_abort_i[i]),
            .clr_i   (sw_clr_i[i]),
            .hit_i   (hit),
            .res_i   (eng_result_i),
            .state_o (st)
        );

        assign pend[i]    = st.pend;
        assign abort_o[i] = st.abort;
        assign done_o[i]  = st.done;
        assign ok_o[i]    = st.ok;
        assign arb_o[i]   = st.arb;
        assign err_o[i]   = st.err;
    end

    assign empty_o = ~pend;

    mbx_rank #(
        .NUM_MBOX (NUM_MBOX),
        .KEY_W    (KEY_W)
    ) u_rank (
        .pend_i (pend),
        .key_i  (key_i),
        .low_o  (low_o)
    );

    mbx_code #(
        .NUM_MBOX (NUM_MBOX),
        .IDX_W    (IDX_W)
    ) u_code (
        .empty_i (empty_o),
        .low_i   (low_o),
        .code_o  (code_o)
    );

endmodule

// File: rtl/mbx_status_checker.sv
// Module: mbx_status_checker
// Concurrent properties on the arbiter's ports, bound into the top module.
// Assumes: engine reports name only existing mailboxes.
module mbx_status_checker #(
    parameter int NUM_MBOX = 3,
    parameter int IDX_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_MBOX-1:0] sw_req_i,
    input logic [NUM_MBOX-1:0] sw_abort_i,
    input logic [NUM_MBOX-1:0] sw_clr_i,
    input logic                eng_done_i,
    input logic [IDX_W-1:0]    eng_mbox_i,
    input logic [1:0]          eng_result_i,
    input logic [NUM_MBOX-1:0] empty_o,
    input logic [NUM_MBOX-1:0] low_o,
    input logic [IDX_W-1:0]    code_o,
    input logic [NUM_MBOX-1:0] abort_o,
    input logic [NUM_MBOX-1:0] done_o,
    input logic [NUM_MBOX-1:0] ok_o,
    input logic [NUM_MBOX-1:0] arb_o,
    input logic [NUM_MBOX-1:0] err_o
);

    p_low_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~empty_o) < 2) |-> (low_o == '0));

    p_low_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(low_o) && ((low_o & empty_o) == '0));

    p_code_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o == '0) |-> low_o[code_o]);

    p_code_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|empty_o) |-> empty_o[code_o]);

    p_abort_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((abort_o & empty_o) == '0));

    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mb
        logic hit_i;
        assign hit_i = eng_done_i && (eng_mbox_i == IDX_W'(i));

        p_code_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
            empty_o[i] |-> (code_o <= IDX_W'(i)));

        p_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_req_i[i] && empty_o[i]) |=> (!empty_o[i] && !done_o[i] && !ok_o[i]));

        p_abort_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_abort_i[i] && empty_o[i]) |=> !abort_o[i]);

        p_success_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i && (eng_result_i == 2'b00) && !empty_o[i])
            |=> (empty_o[i] && done_o[i] && ok_o[i] && !arb_o[i] && !err_o[i]));

        p_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({ok_o[i], arb_o[i], err_o[i]}));

        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_clr_i[i] && !hit_i && !abort_o[i])
            |=> (!done_o[i] && !ok_o[i] && !arb_o[i] && !err_o[i]));

        p_abort_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (abort_o[i] && !(hit_i && (eng_result_i == 2'b00)))
            |=> (empty_o[i] && done_o[i] && !ok_o[i]));

        p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_i && empty_o[i] && !sw_req_i[i] && !sw_clr_i[i])
            |=> ($stable(done_o[i]) && $stable(ok_o[i]) && empty_o[i]));
    end

endmodule

bind mbx_status_arbiter mbx_status_checker #(
    .NUM_MBOX (NUM_MBOX),
    .IDX_W    (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_req_i     (sw_req_i),
    .sw_abort_i   (sw_abort_i),
    .sw_clr_i     (sw_clr_i),
    .eng_done_i   (eng_done_i),
    .eng_mbox_i   (eng_mbox_i),
    .eng_result_i (eng_result_i),
    .empty_o      (empty_o),
    .low_o        (low_o),
    .code_o       (code_o),
    .abort_o      (abort_o),
    .done_o       (done_o),
    .ok_o         (ok_o),
    .arb_o        (arb_o),
    .err_o        (err_o)
);

// File: tb/tb_mbx_status_arbiter.sv
// Directed bench for mbx_status_arbiter: one task per scenario.
module tb_mbx_status_arbiter;

    localparam int N  = 3;
    localparam int KW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  sw_req = '0;
    logic [N-1:0]  sw_abort = '0;
    logic [N-1:0]  sw_clr = '0;
    logic [N*KW-1:0] keys = '0;
    logic          eng_done = 1'b0;
    logic [IW-1:0] eng_mbox = '0;
    logic [1:0]    eng_res = 2'b00;
    logic [N-1:0]  empty, low, abrt, done, ok, arb, err;
    logic [IW-1:0] code;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    mbx_status_arbiter #(.NUM_MBOX(N), .KEY_W(KW)) dut (
        .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req), .sw_abort_i(sw_abort),
        .sw_clr_i(sw_clr), .key_i(keys), .eng_done_i(eng_done),
        .eng_mbox_i(eng_mbox), .eng_result_i(eng_res), .empty_o(empty),
        .low_o(low), .code_o(code), .abort_o(abrt), .done_o(done),
        .ok_o(ok), .arb_o(arb), .err_o(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        sw_req = '0; sw_abort = '0; sw_clr = '0; eng_done = 1'b0;
    endtask

    task automatic set_keys(input int k0, input int k1, input int k2);
        keys = {KW'(k2), KW'(k1), KW'(k0)};
        #1;
    endtask

    task automatic report(input int mb, input logic [1:0] r);
        eng_done = 1'b1; eng_mbox = IW'(mb); eng_res = r;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_keys(0, 0, 0);
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 empty", empty, 3'b111);
        check("R1 flags", {abrt, done, ok, arb, err, low}, 0);
        check("R1 code", code, 0);
    endtask

    task automatic t_request();
        do_reset();
        sw_req = 3'b010; tick();
        check("R2 empty after request", empty, 3'b101);
        check("R4 code lowest free", code, 0);
        check("R3 single pending no flag", low, 0);
        sw_req = 3'b011; tick();
        check("R2 second request", empty, 3'b100);
        check("R4 code only free slot", code, 2);
        sw_req = 3'b010; tick();
        check("R2 request on pending ignored", {empty, done, ok}, {3'b100, 6'b0});
    endtask

    task automatic t_priority();
        do_reset();
        set_keys(5, 5, 3);
        sw_req = 3'b111; tick();
        check("R3 tie resolves toward higher index", low, 3'b010);
        check("R4 code lowest-ranked when full", code, 1);
        set_keys(9, 5, 3);
        check("R3 key change", low, 3'b001);
        check("R4 code follows key", code, 0);
        set_keys(4, 4, 4);
        check("R3 all keys equal", low, 3'b100);
        check("R4 code all equal", code, 2);
    endtask

    task automatic t_success();
        do_reset();
        set_keys(9, 5, 3);
        sw_req = 3'b111; tick();
        report(1, 2'b00); tick();
        check("R6 empty with finish", empty, 3'b010);
        check("R6 finished and ok", {done[1], ok[1], arb[1], err[1]}, 4'b1100);
        check("R4 code freed slot", code, 1);
        check("R3 two remain", low, 3'b001);
        report(1, 2'b00); tick();
        check("R10 report on empty ignored", {empty, done, ok}, {3'b010, 3'b010, 3'b010});
    endtask

    task automatic t_failure();
        do_reset();
        sw_req = 3'b101; tick();
        report(0, 2'b01); tick();
        check("R7 arb lost", {arb[0], err[0], ok[0], done[0], empty[0]}, 5'b10000);
        report(2, 2'b10); tick();
        check("R7 error", {arb[2], err[2], ok[2], empty[2]}, 4'b0100);
        report(0, 2'b11); tick();
        check("R7 error overwrites arb", {arb[0], err[0]}, 2'b01);
    endtask

    task automatic t_abort();
        do_reset();
        sw_req = 3'b100; tick();
        sw_abort = 3'b010; tick();
        check("R5 abort on empty ignored", {abrt, empty}, {3'b000, 3'b011});
        report(2, 2'b10); tick();
        sw_abort = 3'b100; tick();
        check("R5 abort held while pending", {abrt, empty}, {3'b100, 3'b011});
        tick();
        check("R9 abort completes", {abrt, empty}, {3'b000, 3'b111});
        check("R9 finished no ok keeps reason", {done[2], ok[2], err[2]}, 3'b101);
        sw_clr = 3'b100; tick();
        check("R8 clear wipes flags", {done[2], ok[2], arb[2], err[2]}, 0);
    endtask

    task automatic t_abort_vs_success();
        do_reset();
        sw_req = 3'b001; tick();
        sw_abort = 3'b001; tick();
        check("R11 abort flag up", abrt, 3'b001);
        report(0, 2'b00); tick();
        check("R11 success wins", {empty[0], done[0], ok[0], abrt[0]}, 4'b1110);
    endtask

    task automatic t_clear_rules();
        do_reset();
        sw_req = 3'b001; tick();
        report(0, 2'b00); tick();
        sw_clr = 3'b001; tick();
        check("R8 clear after success", {done[0], ok[0]}, 0);
        sw_req = 3'b001; tick();
        report(0, 2'b00); sw_clr = 3'b001; tick();
        check("R8 completion beats clear", {done[0], ok[0]}, 2'b11);
        sw_req = 3'b001; tick();
        check("R2 new request clears finished", {done[0], ok[0], empty[0]}, 0);
    endtask

    initial begin
        #(4 * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        t_request();
        t_priority();
        t_success();
        t_failure();
        t_abort();
        t_abort_vs_success();
        t_clear_rules();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule